// File: doc/BRIEF.md
# Guard-Bit Accumulator Arithmetic/Logic Unit

This block is the arithmetic and logic stage of a signal-processing datapath. It holds two 40-bit accumulators and, on each accepted operation, combines two 40-bit operands. The first operand is the destination accumulator or the first 16-bit memory bus. The second operand is the other accumulator or the second 16-bit memory bus. The result is written back into the destination accumulator one clock later. Sixteen-bit bus values are widened to 40 bits by sign or zero extension, as a mode input selects.

Three mode inputs change how arithmetic behaves:
- A saturation enable clamps results that leave the signed 32-bit range. The eight guard bits above that range keep the true value when saturation is off.
- A dual-lane mode cuts the adder between bits 15 and 16, so two independent sums are formed at once.
- The sign-extension mode described above.

Each accumulator has a sticky overflow flag and a zero flag. A shared carry flag and a test flag hold the result of an equality compare.

Top module: `acc_alu40`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both accumulators, the carry, both overflow flags and the test flag read 0, and both zero flags read 1.
- R2: When `op_valid_i` is high, op codes 0 (add), 1 (subtract, first operand minus second), 2 (AND), 3 (OR) and 4 (XOR) write their result into the accumulator chosen by `dst_i` (0 = A, 1 = B). The result is visible from the next clock edge. The first operand is that accumulator when `xsel_i`=0, or the widened C bus when `xsel_i`=1. The second operand is the other accumulator when `ysel_i`=0, or the widened D bus when `ysel_i`=1.
- R3: A bus operand is widened by copying bit 15 into bits 39..16 when `sign_ext_i`=1, and by filling bits 39..16 with zeros when `sign_ext_i`=0.
- R4: An add or subtract overflows when, outside dual-lane mode, its exact signed result lies outside the range -2^31 to 2^31-1. With `sat_en_i`=1, the written value is then 0x007FFFFFFF for a positive result and 0xFF80000000 for a negative one. With `sat_en_i`=0, the low 40 bits of the exact result are written.
- R5: An overflow sets the destination's overflow flag whatever `sat_en_i` is. The flag stays set until op code 6 is issued with that accumulator as destination, which clears it and changes nothing else.
- R6: Each accumulator's zero flag is 1 exactly when the latest value written into that accumulator is zero.
- R7: The carry flag is updated only by add and subtract. For add it is the unsigned carry out of the top bit. For subtract it is 1 when no borrow occurs, that is, when the first operand is not smaller than the second as unsigned numbers. Logic ops leave the carry unchanged.
- R8: With `dual_i`=1, add and subtract treat bits 15..0 and bits 39..16 as separate lanes with no carry between them. The carry flag takes the carry out of the upper lane. No overflow is detected and no saturation is applied.
- R9: Op code 5 sets the test flag to 1 when the two selected operands are equal and to 0 otherwise. It writes no accumulator and changes no other flag.
- R10: A cycle with `op_valid_i`=0, or with op code 7, changes no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 3 | Operation code |
| dst_i | input | 1 | Destination accumulator, 0 = A, 1 = B |
| xsel_i | input | 1 | First operand: destination accumulator or C bus |
| ysel_i | input | 1 | Second operand: other accumulator or D bus |
| sign_ext_i | input | 1 | Sign-extend bus operands |
| sat_en_i | input | 1 | Saturate on overflow |
| dual_i | input | 1 | Dual 16/24-bit lane mode |
| cbus_i | input | 16 | First memory data bus |
| dbus_i | input | 16 | Second memory data bus |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| carry_o | output | 1 | Shared carry flag |
| ovf_a_o | output | 1 | Sticky overflow flag of A |
| ovf_b_o | output | 1 | Sticky overflow flag of B |
| zero_a_o | output | 1 | Zero flag of A |
| zero_b_o | output | 1 | Zero flag of B |
| tc_o | output | 1 | Compare (test) flag |

## Verification
A saturating add updates several pieces of state on the same clock edge: the accumulator value, its sticky overflow flag, its zero flag and the shared carry. The saturation path and the dual-lane path also compete for the same write. The bench provokes both situations with a doubling chain that walks an accumulator across the 32-bit boundary, repeated under all eight combinations of the three mode inputs, and mixes this with random operations. After every operation it compares the whole visible state against its own model, so any flag updated in the wrong cycle, or saturation applied in dual-lane mode, is reported.

// File: rtl/alu40_pkg.sv
package alu40_pkg;
   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_CMPEQ = 3'd5,
      OP_CLROV = 3'd6,
      OP_NOP   = 3'd7
   } alu_op_e;
endpackage

// File: rtl/acc_alu40_opsel.sv
// Operand multiplexers with selectable widening of bus data.
module acc_alu40_opsel #(
   parameter int ACC_W = 40,
   parameter int BUS_W = 16
) (
   input  logic             sign_ext_i,
   input  logic             xsel_i,
   input  logic             ysel_i,
   input  logic             dst_i,
   input  logic [ACC_W-1:0] acc_a_i,
   input  logic [ACC_W-1:0] acc_b_i,
   input  logic [BUS_W-1:0] cbus_i,
   input  logic [BUS_W-1:0] dbus_i,
   output logic [ACC_W-1:0] x_o,
   output logic [ACC_W-1:0] y_o
);
   localparam int PAD_W = ACC_W - BUS_W;

   function automatic logic [ACC_W-1:0] widen(input logic [BUS_W-1:0] v, input logic se);
      return {{PAD_W{se & v[BUS_W-1]}}, v};
   endfunction

   logic [ACC_W-1:0] own_acc, other_acc;

   always_comb begin
      own_acc   = dst_i ? acc_b_i : acc_a_i;
      other_acc = dst_i ? acc_a_i : acc_b_i;
      x_o = xsel_i ? widen(cbus_i, sign_ext_i) : own_acc;
      y_o = ysel_i ? widen(dbus_i, sign_ext_i) : other_acc;
   end
endmodule

// File: rtl/acc_alu40_core.sv
// Two-lane adder/subtractor: lane cut at LANE_W when dual mode is set.
module acc_alu40_core #(
   parameter int ACC_W  = 40,
   parameter int LANE_W = 16
) (
   input  logic             sub_i,
   input  logic             dual_i,
   input  logic [ACC_W-1:0] x_i,
   input  logic [ACC_W-1:0] y_i,
   output logic [ACC_W-1:0] wrap_o,
   output logic             carry_o,
   output logic [ACC_W:0]   wide_o
);
   localparam int HI_W = ACC_W - LANE_W;

   logic [ACC_W-1:0]  yv;
   logic [LANE_W:0]   lo_sum;
   logic [HI_W:0]     hi_sum;
   logic              hi_cin;

   always_comb begin
      yv     = sub_i ? ~y_i : y_i;
      lo_sum = {1'b0, x_i[LANE_W-1:0]} + {1'b0, yv[LANE_W-1:0]} + {{LANE_W{1'b0}}, sub_i};
      hi_cin = dual_i ? sub_i : lo_sum[LANE_W];
      hi_sum = {1'b0, x_i[ACC_W-1:LANE_W]} + {1'b0, yv[ACC_W-1:LANE_W]} + {{HI_W{1'b0}}, hi_cin};
      wrap_o  = {hi_sum[HI_W-1:0], lo_sum[LANE_W-1:0]};
      carry_o = hi_sum[HI_W];
      wide_o  = {x_i[ACC_W-1], x_i} + {yv[ACC_W-1], yv} + {{ACC_W{1'b0}}, sub_i};
   end
endmodule

// File: rtl/acc_alu40_sat.sv
// Range check against the SAT_W-bit signed window and optional clamp.
module acc_alu40_sat #(
   parameter int ACC_W = 40,
   parameter int SAT_W = 32
) (
   input  logic             sat_en_i,
   input  logic [ACC_W:0]   wide_i,
   input  logic [ACC_W-1:0] wrap_i,
   output logic [ACC_W-1:0] res_o,
   output logic             ovf_o
);
   localparam int TOP_W = ACC_W - SAT_W + 2;
   localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

   logic [TOP_W-1:0] top_bits;

   always_comb begin
      top_bits = wide_i[ACC_W:SAT_W-1];
      ovf_o    = !((&top_bits) || !(|top_bits));
      if (sat_en_i && ovf_o)
         res_o = wide_i[ACC_W] ? NEG_LIM : POS_LIM;
      else
         res_o = wrap_i;
   end
endmodule

// File: rtl/acc_alu40.sv
module acc_alu40
   import alu40_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int BUS_W = 16,
   parameter int SAT_W = 32,
   parameter int N_ACC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid_i,
   input  logic [2:0]       op_i,
   input  logic             dst_i,
   input  logic             xsel_i,
   input  logic             ysel_i,
   input  logic             sign_ext_i,
   input  logic             sat_en_i,
   input  logic             dual_i,
   input  logic [BUS_W-1:0] cbus_i,
   input  logic [BUS_W-1:0] dbus_i,
   output logic [ACC_W-1:0] acc_a_o,
   output logic [ACC_W-1:0] acc_b_o,
   output logic             carry_o,
   output logic             ovf_a_o,
   output logic             ovf_b_o,
   output logic             zero_a_o,
   output logic             zero_b_o,
   output logic             tc_o
);
   generate
      if (SAT_W >= ACC_W || SAT_W <= BUS_W) begin : g_bad_sat
         $error("SAT_W must lie between BUS_W and ACC_W");
      end
      if (2 * BUS_W > ACC_W) begin : g_bad_lane
         $error("ACC_W must hold two bus-wide lanes");
      end
      if (N_ACC != 2) begin : g_bad_acc
         $error("exactly two accumulators are supported");
      end
   endgenerate

   alu_op_e          op;
   logic [ACC_W-1:0] acc_q [N_ACC];
   logic [N_ACC-1:0] ovf_q, zero_q;
   logic [ACC_W-1:0] x, y, wrap, sat_res, logic_res, result;
   logic [ACC_W:0]   wide;
   logic             carry_raw, ovf_raw, arith_op, logic_op, wr_en, ovf_ev;
   logic             carry_q, tc_q;

   assign op = alu_op_e'(op_i);

   acc_alu40_opsel #(.ACC_W(ACC_W), .BUS_W(BUS_W)) u_opsel (
      .sign_ext_i(sign_ext_i), .xsel_i(xsel_i), .ysel_i(ysel_i), .dst_i(dst_i),
      .acc_a_i(acc_q[0]), .acc_b_i(acc_q[1]), .cbus_i(cbus_i), .dbus_i(dbus_i),
      .x_o(x), .y_o(y)
   );

   acc_alu40_core #(.ACC_W(ACC_W), .LANE_W(BUS_W)) u_core (
      .sub_i(op == OP_SUB), .dual_i(dual_i), .x_i(x), .y_i(y),
      .wrap_o(wrap), .carry_o(carry_raw), .wide_o(wide)
   );

   acc_alu40_sat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_sat (
      .sat_en_i(sat_en_i & ~dual_i), .wide_i(wide), .wrap_i(wrap),
      .res_o(sat_res), .ovf_o(ovf_raw)
   );

   always_comb begin
      arith_op = (op == OP_ADD) || (op == OP_SUB);
      logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
      unique case (op)
         OP_AND:  logic_res = x & y;
         OP_OR:   logic_res = x | y;
         default: logic_res = x ^ y;
      endcase
      result = arith_op ? sat_res : logic_res;
      wr_en  = op_valid_i && (arith_op || logic_op);
      ovf_ev = op_valid_i && arith_op && !dual_i && ovf_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         tc_q    <= 1'b0;
      end else if (op_valid_i) begin
         if (arith_op)         carry_q <= carry_raw;
         if (op == OP_CMPEQ)   tc_q    <= (x == y);
      end
   end

   for (genvar g = 0; g < N_ACC; g++) begin : g_acc
      logic sel;
      assign sel = (dst_i == (g != 0));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q[g]  <= '0;
            zero_q[g] <= 1'b1;
            ovf_q[g]  <= 1'b0;
         end else begin
            if (wr_en && sel) begin
               acc_q[g]  <= result;
               zero_q[g] <= (result == '0);
            end
            if (op_valid_i && op == OP_CLROV && sel)
               ovf_q[g] <= 1'b0;
            else if (ovf_ev && sel)
               ovf_q[g] <= 1'b1;
         end
      end
   end

   assign acc_a_o  = acc_q[0];
   assign acc_b_o  = acc_q[1];
   assign carry_o  = carry_q;
   assign ovf_a_o  = ovf_q[0];
   assign ovf_b_o  = ovf_q[1];
   assign zero_a_o = zero_q[0];
   assign zero_b_o = zero_q[1];
   assign tc_o     = tc_q;
endmodule

// File: rtl/acc_alu40_chk.sv
module acc_alu40_chk #(
   parameter int ACC_W = 40,
   parameter int SAT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid_i,
   input logic [2:0]       op_i,
   input logic             dst_i,
   input logic             sat_en_i,
   input logic             dual_i,
   input logic [ACC_W-1:0] acc_a_o,
   input logic [ACC_W-1:0] acc_b_o,
   input logic             ovf_a_o,
   input logic             ovf_b_o,
   input logic             zero_a_o,
   input logic             zero_b_o,
   input logic             tc_o
);
   logic sat_wr_a, clr_a, clr_b, cmp_op, idle;
   assign sat_wr_a = op_valid_i && (op_i == 3'd0 || op_i == 3'd1) && sat_en_i && !dual_i && !dst_i;
   assign clr_a    = op_valid_i && op_i == 3'd6 && !dst_i;
   assign clr_b    = op_valid_i && op_i == 3'd6 && dst_i;
   assign cmp_op   = op_valid_i && op_i == 3'd5;
   assign idle     = !op_valid_i || op_i == 3'd7;

   assert_sat_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sat_wr_a |=> ((&acc_a_o[ACC_W-1:SAT_W-1]) || !(|acc_a_o[ACC_W-1:SAT_W-1])));

   assert_ovf_a_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_a_o) |-> $past(clr_a));

   assert_ovf_b_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_b_o) |-> $past(clr_b));

   assert_zero_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_a_o == (acc_a_o == '0));

   assert_zero_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_b_o == (acc_b_o == '0));

   assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_op |=> ($stable(acc_a_o) && $stable(acc_b_o)));

   assert_tc_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_op |=> $stable(tc_o));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(ovf_a_o) && $stable(ovf_b_o)));
endmodule

bind acc_alu40 acc_alu40_chk #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i), .dst_i(dst_i),
   .sat_en_i(sat_en_i), .dual_i(dual_i), .acc_a_o(acc_a_o), .acc_b_o(acc_b_o),
   .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o), .zero_a_o(zero_a_o), .zero_b_o(zero_b_o),
   .tc_o(tc_o)
);

// File: tb/acc_alu40_bench.sv
`timescale 1ns/1ps
module acc_alu40_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [2:0]  op_i = 3'd7;
   logic        dst_i = 1'b0, xsel_i = 1'b0, ysel_i = 1'b0;
   logic        sign_ext_i = 1'b0, sat_en_i = 1'b0, dual_i = 1'b0;
   logic [15:0] cbus_i = '0, dbus_i = '0;
   logic [39:0] acc_a_o, acc_b_o;
   logic        carry_o, ovf_a_o, ovf_b_o, zero_a_o, zero_b_o, tc_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   logic [39:0] ma = '0, mb = '0;
   logic        mc = 0, mova = 0, movb = 0, mza = 1, mzb = 1, mtc = 0;

   always #4 clk = ~clk;

   acc_alu40 u_acc_alu40 (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i), .dst_i(dst_i),
      .xsel_i(xsel_i), .ysel_i(ysel_i), .sign_ext_i(sign_ext_i), .sat_en_i(sat_en_i),
      .dual_i(dual_i), .cbus_i(cbus_i), .dbus_i(dbus_i), .acc_a_o(acc_a_o),
      .acc_b_o(acc_b_o), .carry_o(carry_o), .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o),
      .zero_a_o(zero_a_o), .zero_b_o(zero_b_o), .tc_o(tc_o)
   );

   function automatic logic [39:0] ext16(input logic [15:0] v, input logic se);
      return se ? {{24{v[15]}}, v} : {24'h0, v};
   endfunction

   task automatic compare(input string tag);
      logic [85:0] got, exp;
      got = {acc_a_o, acc_b_o, carry_o, ovf_a_o, ovf_b_o, zero_a_o, zero_b_o, tc_o};
      exp = {ma, mb, mc, mova, movb, mza, mzb, mtc};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // apply one operation to the model; returns requirement tag
   function automatic string model_step(input logic [2:0] op, input logic dst, input logic xs,
         input logic ys, input logic se, input logic sat, input logic dual,
         input logic [15:0] c, input logic [15:0] d);
      logic [39:0] own, oth, x, y, r;
      longint sx, sy, s;
      logic ov, cy, wr;
      string tag;
      own = dst ? mb : ma;
      oth = dst ? ma : mb;
      x = xs ? ext16(c, se) : own;
      y = ys ? ext16(d, se) : oth;
      ov = 0; wr = 0; cy = mc; r = '0; tag = "R2";
      case (op)
         3'd0, 3'd1: begin
            wr = 1;
            if (dual) begin
               logic [15:0] lo;
               logic [24:0] hi;
               lo = (op == 3'd0) ? x[15:0] + y[15:0] : x[15:0] - y[15:0];
               if (op == 3'd0) begin
                  hi = {1'b0, x[39:16]} + {1'b0, y[39:16]};
                  cy = hi[24];
               end else begin
                  hi = {1'b0, x[39:16] - y[39:16]};
                  cy = (x[39:16] >= y[39:16]);
               end
               r = {hi[23:0], lo};
               tag = "R8";
            end else begin
               sx = {{24{x[39]}}, x};
               sy = {{24{y[39]}}, y};
               s  = (op == 3'd0) ? sx + sy : sx - sy;
               ov = (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
               if (op == 3'd0) cy = ({1'b0, x} + {1'b0, y}) >> 40;
               else            cy = (x >= y);
               r = s[39:0];
               if (ov && sat) r = (s < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
               tag = ov ? (sat ? "R4" : "R5") : ((xs || ys) ? "R3" : "R2");
            end
         end
         3'd2: begin wr = 1; r = x & y; end
         3'd3: begin wr = 1; r = x | y; end
         3'd4: begin wr = 1; r = x ^ y; end
         3'd5: begin mtc = (x == y); tag = "R9"; end
         3'd6: begin
            if (dst) movb = 0; else mova = 0;
            tag = "R5";
         end
         default: tag = "R10";
      endcase
      mc = cy;
      if (wr) begin
         if (dst) begin mb = r; mzb = (r == 0); if (ov) movb = 1; end
         else     begin ma = r; mza = (r == 0); if (ov) mova = 1; end
      end
      return tag;
   endfunction

   task automatic issue(input logic [2:0] op, input logic dst, input logic xs, input logic ys,
         input logic se, input logic sat, input logic dual,
         input logic [15:0] c, input logic [15:0] d, input string tag_ovr);
      string tag;
      @(negedge clk);
      op_valid_i = 1; op_i = op; dst_i = dst; xsel_i = xs; ysel_i = ys;
      sign_ext_i = se; sat_en_i = sat; dual_i = dual; cbus_i = c; dbus_i = d;
      tag = model_step(op, dst, xs, ys, se, sat, dual, c, d);
      if (tag_ovr != "") tag = tag_ovr;
      @(negedge clk);
      op_valid_i = 0;
      compare(tag);
   endtask

   // R10: idle cycle with busy inputs must change nothing
   task automatic idle_cycle();
      @(negedge clk);
      op_valid_i = 0; op_i = 3'($urandom()); dst_i = 1'($urandom());
      xsel_i = 1'($urandom()); ysel_i = 1'($urandom());
      cbus_i = 16'($urandom()); dbus_i = 16'($urandom());
      @(negedge clk);
      compare("R10");
   endtask

   function automatic logic [15:0] pick16();
      case ($urandom_range(0, 5))
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         3: return 16'h0000;
         default: return 16'($urandom());
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      compare("R1");   // reset held
      rst_n = 1;
      @(negedge clk);
      compare("R1");   // first cycle after release

      for (int m = 0; m < 8; m++) begin
         logic se, sat, dual;
         se = m[0]; sat = m[1]; dual = m[2];
         issue(3'd0, 0, 1, 1, se, sat, dual, 16'h8000, 16'h0001, "R3");
         issue(3'd0, 1, 1, 0, se, sat, dual, 16'h0000, 16'h0000, "");
         issue(3'd5, 0, 0, 0, se, sat, dual, 16'h0, 16'h0, "R9");
         issue(3'd1, 0, 0, 0, se, sat, dual, 16'h0, 16'h0, "R6");
         issue(3'd5, 0, 0, 1, se, sat, dual, 16'h0, 16'h0001, "R9");
         issue(3'd0, 0, 1, 1, se, sat, dual, 16'hFFFF, 16'h0001, "R7");
         issue(3'd2, 0, 1, 1, se, sat, dual, 16'hF0F0, 16'h0FF0, "R7");
         issue(3'd1, 0, 1, 1, se, sat, dual, 16'h0001, 16'h0002, "R7");
         // doubling chain across the 32-bit boundary
         issue(3'd0, 0, 1, 1, se, sat, dual, 16'h7FFF, 16'h7FFF, "");
         for (int k = 0; k < 20; k++) begin
            issue(3'd0, 1, 1, 0, se, sat, dual, 16'h0000, 16'h0000, "");
            issue(3'd0, 0, 0, 0, se, sat, dual, 16'h0000, 16'h0000, "");
         end
         issue(3'd1, 0, 0, 0, se, sat, dual, 16'h0, 16'h0, "");
         idle_cycle();
         issue(3'd7, 0, 1, 1, se, sat, dual, 16'h1234, 16'h5678, "R10");
         issue(3'd6, 0, 0, 0, se, sat, dual, 16'h0, 16'h0, "R5");
         issue(3'd6, 1, 0, 0, se, sat, dual, 16'h0, 16'h0, "R5");
         // negative doubling chain
         issue(3'd0, 1, 1, 1, se, sat, dual, 16'h8000, 16'h8000, "");
         for (int k = 0; k < 18; k++) begin
            issue(3'd0, 0, 1, 0, se, sat, dual, 16'h0000, 16'h0000, "");
            issue(3'd0, 1, 0, 0, se, sat, dual, 16'h0000, 16'h0000, "");
         end
         for (int k = 0; k < 300; k++) begin
            logic [2:0] op;
            op = ($urandom_range(0, 9) < 6) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(2, 7));
            if ($urandom_range(0, 15) == 0) idle_cycle();
            issue(op, 1'($urandom()), 1'($urandom()), 1'($urandom()), se, sat, dual,
                  pick16(), pick16(), "");
         end
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog: got still running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule